// File: doc/BRIEF.md
# D-PHY Data Lane Burst Sequencer

This block drives one data lane of a D-PHY style transmitter through a single high-speed burst. When a burst is requested and the clock lane reports that it is ready, the lane leaves the stop state. It requests high-speed mode, prepares the line, and holds the zero level. It then sends a sync byte and streams payload bytes. After the last byte it drives a trail level opposite to the final serialized bit, and it returns to the stop state for the exit interval. Every interval is a programmable count of system clock cycles. The line state and the byte to be serialized appear on the outputs, and a downstream serializer and line driver turn them into electrical levels.

Payload arrives on a valid/ready stream. Ready is high only during the payload phase, and a byte is taken on every clock edge where valid and ready are both high. The producer must hold valid high without gaps for the whole payload. The first payload cycle with valid low ends the burst. If valid is low in the very first payload cycle, the burst carries the sync byte alone. A valid byte offered outside the payload phase stays pending and is not consumed. The configuration inputs must stay stable while a burst is in progress. When the exit interval ends, a one-cycle done pulse is raised, and the clock lane can use it to time its own post interval.

The encoding of `line_state` is 0 = LP-11 (stop), 1 = LP-01 (HS request), 2 = LP-00 (prepare), 3 = HS-0, 4 = HS-1, 5 = HS data (`tx_byte` is being serialized).

Top module: `dphy_lane_burst_seq`

## Requirements
- R1: While reset is asserted, `line_state` is 0 (LP-11) and `s_ready`, `tx_vld` and `burst_done` are low.
- R2: From the idle stop state, a burst starts only on a clock edge where `start` and `clk_lane_ready` are both high. Otherwise `line_state` stays 0.
- R3: A burst opens with LP-01 (code 1) for `cfg_lpx` cycles, followed by LP-00 (code 2) for the larger of `cfg_prepare` and `cfg_lpx` cycles.
- R4: After LP-00 the lane drives HS-0 (code 3) for `cfg_zero` cycles and then enters HS data (code 5).
- R5: The first HS data cycle shows `tx_byte` = 8'h1D (the sync byte). Each later HS data cycle shows the next accepted payload byte, in arrival order. `tx_vld` is high exactly in HS data cycles.
- R6: `s_ready` is high only in HS data cycles, and the number of bytes accepted in a burst equals the number the producer offered in its unbroken run.
- R7: The first HS data cycle with `s_valid` low is the last HS data cycle, so a burst with n payload bytes has n+1 HS data cycles. With n = 0 the burst still completes.
- R8: The trail drives HS-1 (code 4) if bit 7 of the last byte shown is 0, and HS-0 (code 3) if it is 1, for `cfg_trail` cycles. Bit 7 is the last bit serialized (LSB first).
- R9: After the trail, LP-11 is held for the larger of `cfg_exit` and `cfg_lpx` cycles. `burst_done` is then high for exactly one cycle, the first idle cycle.
- R10: `trail_short` is high exactly when `cfg_trail` < max(8·`cfg_hs_period`, `cfg_t60` + 4·`cfg_hs_period`).
- R11: An interval programmed as 0 lasts one cycle.
- R12: If `start` is still high when `burst_done` is raised, LP-01 of the next burst appears in the cycle right after the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request, level sensitive, sampled in idle |
| clk_lane_ready | input | 1 | Clock lane is running in HS mode |
| cfg_lpx | input | CW | Minimum low-power state length, cycles |
| cfg_prepare | input | CW | LP-00 prepare length, cycles |
| cfg_zero | input | CW | HS-0 zero length, cycles |
| cfg_trail | input | CW | Trail length, cycles |
| cfg_exit | input | CW | LP-11 exit length, cycles |
| cfg_hs_period | input | CW | HS clock period, cycles (trail floor check) |
| cfg_t60 | input | CW | 60 ns expressed in cycles (trail floor check) |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | DW | Payload byte |
| s_ready | output | 1 | Payload byte accepted this edge when valid |
| line_state | output | 3 | Lane state code (see encoding) |
| tx_byte | output | DW | Byte to serialize in HS data cycles |
| tx_vld | output | 1 | `tx_byte` is live |
| burst_done | output | 1 | One-cycle pulse at end of exit |
| trail_short | output | 1 | Programmed trail is below its floor |

## Verification
Two events can fall in the same cycle here: the done pulse that closes one burst, and the acceptance of the request that opens the next one. The bench provokes this by holding `start` high through an entire burst. It then judges that done lasts one cycle and that LP-01 follows it immediately, with no extra stop cycle. Inside the payload, the acceptance of the final byte and the close of the stream meet at the same boundary. This is judged by counting HS data cycles against bytes offered, including the empty-stream burst, and by the trail polarity that the last shown byte selects.

// File: rtl/dphy_seq_pkg.sv
`timescale 1ns/1ps
package dphy_seq_pkg;
  typedef enum logic [2:0] {
    LN_LP11  = 3'd0,
    LN_LP01  = 3'd1,
    LN_LP00  = 3'd2,
    LN_HS0   = 3'd3,
    LN_HS1   = 3'd4,
    LN_HSDAT = 3'd5
  } line_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_PREP, ST_ZERO, ST_PAY, ST_TRAIL, ST_EXIT
  } seq_e;

  localparam logic [7:0] SYNC_BYTE = 8'h1D;
endpackage

// File: rtl/dphy_phase_timer.sv
`timescale 1ns/1ps
module dphy_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] len,
  output logic          expired
);
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + (CW+1)'(1);
  // a zero length behaves like one cycle
  assign expired = cnt_inc >= {1'b0, len};

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (!expired) cnt <= cnt_inc[CW-1:0];
  end
endmodule

// File: rtl/dphy_trail_floor.sv
`timescale 1ns/1ps
module dphy_trail_floor #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] hs_period,
  input  logic [CW-1:0] t60,
  input  logic [CW-1:0] trail,
  output logic          short_o
);
  localparam int XW = CW + 3;
  logic [XW-1:0] eight_p, four_p_t60, floor_v;

  assign eight_p    = {hs_period, 3'b000};
  assign four_p_t60 = {3'b000, t60} + {1'b0, hs_period, 2'b00};
  assign floor_v    = (eight_p > four_p_t60) ? eight_p : four_p_t60;
  assign short_o    = {3'b000, trail} < floor_v;
endmodule

// File: rtl/dphy_hs_byte_path.sv
`timescale 1ns/1ps
module dphy_hs_byte_path
  import dphy_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_sync,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] byte_q,
  output logic          last_bit
);
  localparam logic [DW-1:0] SYNC_W = DW'(SYNC_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n)         byte_q <= '0;
    else if (load_sync) byte_q <= SYNC_W;
    else if (take)      byte_q <= din;
  end

  // serialized LSB first, so the top bit leaves the lane last
  assign last_bit = byte_q[DW-1];
endmodule

// File: rtl/dphy_lane_burst_seq.sv
`timescale 1ns/1ps
module dphy_lane_burst_seq
  import dphy_seq_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clk_lane_ready,
  input  logic [CW-1:0] cfg_lpx,
  input  logic [CW-1:0] cfg_prepare,
  input  logic [CW-1:0] cfg_zero,
  input  logic [CW-1:0] cfg_trail,
  input  logic [CW-1:0] cfg_exit,
  input  logic [CW-1:0] cfg_hs_period,
  input  logic [CW-1:0] cfg_t60,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic [2:0]    line_state,
  output logic [DW-1:0] tx_byte,
  output logic          tx_vld,
  output logic          burst_done,
  output logic          trail_short
);
  seq_e          st, nxt;
  logic [CW-1:0] phase_len, prep_len, exit_len;
  logic          ph_exp, ph_clr;
  logic          last_bit;
  logic          done_q;
  line_e         ln;

  // low-power phases never shorter than the LP minimum
  assign prep_len = (cfg_prepare > cfg_lpx) ? cfg_prepare : cfg_lpx;
  assign exit_len = (cfg_exit    > cfg_lpx) ? cfg_exit    : cfg_lpx;

  always_comb begin
    case (st)
      ST_PREP:  phase_len = prep_len;
      ST_ZERO:  phase_len = cfg_zero;
      ST_TRAIL: phase_len = cfg_trail;
      ST_EXIT:  phase_len = exit_len;
      default:  phase_len = cfg_lpx;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (start && clk_lane_ready) nxt = ST_REQ;
      ST_REQ:   if (ph_exp) nxt = ST_PREP;
      ST_PREP:  if (ph_exp) nxt = ST_ZERO;
      ST_ZERO:  if (ph_exp) nxt = ST_PAY;
      ST_PAY:   if (!s_valid) nxt = ST_TRAIL;
      ST_TRAIL: if (ph_exp) nxt = ST_EXIT;
      ST_EXIT:  if (ph_exp) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign ph_clr = (nxt != st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st     <= nxt;
      done_q <= (st == ST_EXIT) && ph_exp;
    end
  end

  dphy_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ph_clr),
    .len     (phase_len),
    .expired (ph_exp)
  );

  dphy_hs_byte_path #(.DW(DW)) u_bytes (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_sync ((st == ST_ZERO) && ph_exp),
    .take      ((st == ST_PAY) && s_valid),
    .din       (s_data),
    .byte_q    (tx_byte),
    .last_bit  (last_bit)
  );

  dphy_trail_floor #(.CW(CW)) u_floor (
    .hs_period (cfg_hs_period),
    .t60       (cfg_t60),
    .trail     (cfg_trail),
    .short_o   (trail_short)
  );

  always_comb begin
    case (st)
      ST_REQ:   ln = LN_LP01;
      ST_PREP:  ln = LN_LP00;
      ST_ZERO:  ln = LN_HS0;
      ST_PAY:   ln = LN_HSDAT;
      ST_TRAIL: ln = last_bit ? LN_HS0 : LN_HS1;
      default:  ln = LN_LP11;
    endcase
  end

  assign line_state = ln;
  assign s_ready    = (st == ST_PAY);
  assign tx_vld     = (st == ST_PAY);
  assign burst_done = done_q;
endmodule

// File: rtl/dphy_seq_props.sv
`timescale 1ns/1ps
module dphy_seq_props
  import dphy_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       clk_lane_ready,
  input logic       s_valid,
  input logic       s_ready,
  input logic [2:0] line_state,
  input logic       tx_vld,
  input logic       burst_done
);
  // R6
  ready_in_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> line_state == LN_HSDAT);

  // R2
  hold_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LN_LP11 && !clk_lane_ready) |=> line_state == LN_LP11);

  // R3
  lp00_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LN_LP00 && $past(line_state) != LN_LP00) |-> $past(line_state) == LN_LP01);

  // R4
  data_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_vld) |-> $past(line_state) == LN_HS0);

  // R7
  gap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LN_HSDAT && !s_valid) |=> line_state != LN_HSDAT);

  // R8
  trail_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_state) == LN_HSDAT && line_state != LN_HSDAT)
      |-> (line_state == LN_HS0 || line_state == LN_HS1));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R9
  done_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (line_state == LN_LP11 && $past(line_state) == LN_LP11));
endmodule

bind dphy_lane_burst_seq dphy_seq_props u_props (
  .clk            (clk),
  .rst_n          (rst_n),
  .clk_lane_ready (clk_lane_ready),
  .s_valid        (s_valid),
  .s_ready        (s_ready),
  .line_state     (line_state),
  .tx_vld         (tx_vld),
  .burst_done     (burst_done)
);

// File: tb/tb_dphy_lane_burst_seq.sv
`timescale 1ns/1ps
module tb_dphy_lane_burst_seq;
  logic       clk = 1'b0;
  logic       rst_n, start, clk_lane_ready, s_valid;
  logic [7:0] cfg_lpx, cfg_prepare, cfg_zero, cfg_trail, cfg_exit, cfg_hs_period, cfg_t60;
  logic [7:0] s_data, tx_byte;
  logic       s_ready, tx_vld, burst_done, trail_short;
  logic [2:0] line_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dphy_lane_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_lane_ready(clk_lane_ready),
    .cfg_lpx(cfg_lpx), .cfg_prepare(cfg_prepare), .cfg_zero(cfg_zero),
    .cfg_trail(cfg_trail), .cfg_exit(cfg_exit), .cfg_hs_period(cfg_hs_period),
    .cfg_t60(cfg_t60), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .line_state(line_state), .tx_byte(tx_byte), .tx_vld(tx_vld),
    .burst_done(burst_done), .trail_short(trail_short)
  );

  // {lpx, prepare, zero, trail, exit, nbytes, first byte}
  localparam logic [55:0] VECS [6] = '{
    56'h04060507090310,
    56'h06030204020000,
    56'h01000000000180,
    56'h03080A0C1405F0,
    56'h0202030504087C,
    56'h050501030702FE
  };

  logic [2:0] ls_tr [0:1023];
  logic [7:0] by_tr [0:1023];
  logic       dn_tr [0:1023];
  int         tr_n;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int run_len(input int from);
    int k = 0;
    while (from + k < tr_n && ls_tr[from + k] == ls_tr[from]) k++;
    return k;
  endfunction

  function automatic int m1(input int a);
    return (a == 0) ? 1 : a;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic capture(input int n, input logic [7:0] base, input bit hold, output int taken);
    int sent = 0;
    tr_n    = 0;
    s_valid = (n > 0);
    s_data  = base;
    start   = 1'b1;
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk);
      if (!hold) start = 1'b0;
      ls_tr[tr_n] = line_state;
      by_tr[tr_n] = tx_byte;
      dn_tr[tr_n] = burst_done;
      tr_n++;
      if (burst_done) break;
      s_valid = (sent < n);
      s_data  = base + 8'(sent);
      if (s_ready && s_valid) sent++;
    end
    s_valid = 1'b0;
    taken   = sent;
  endtask

  task automatic check_burst(input logic [55:0] v, input bit hold);
    int lpx_e, prep_e, zero_e, trail_e, exit_e, n, idx, k, bad, taken;
    logic [7:0] base, last, expb;
    logic [2:0] tls;
    cfg_lpx = v[55:48]; cfg_prepare = v[47:40]; cfg_zero = v[39:32];
    cfg_trail = v[31:24]; cfg_exit = v[23:16];
    n = int'(v[15:8]); base = v[7:0];
    lpx_e   = m1(int'(cfg_lpx));
    prep_e  = mx(m1(int'(cfg_prepare)), lpx_e);
    zero_e  = m1(int'(cfg_zero));
    trail_e = m1(int'(cfg_trail));
    exit_e  = mx(m1(int'(cfg_exit)), lpx_e);
    last    = (n == 0) ? 8'h1D : base + 8'(n - 1);
    tls     = last[7] ? 3'd3 : 3'd4;

    capture(n, base, hold, taken);

    idx = 0;
    k = run_len(idx);
    chk(ls_tr[idx] == 3'd1 && k == lpx_e, "R3 LP-01 length", k, lpx_e);
    idx += k;
    k = run_len(idx);
    chk(ls_tr[idx] == 3'd2 && k == prep_e, "R3 LP-00 length", k, prep_e);
    idx += k;
    k = run_len(idx);
    chk(ls_tr[idx] == 3'd3 && k == zero_e, "R4 HS-0 zero length", k, zero_e);
    idx += k;
    k = run_len(idx);
    chk(ls_tr[idx] == 3'd5 && k == n + 1, "R7 HS data cycles", k, n + 1);
    bad = 0;
    for (int j = 0; j < k; j++) begin
      expb = (j == 0) ? 8'h1D : base + 8'(j - 1);
      if (by_tr[idx + j] != expb) bad++;
    end
    chk(bad == 0, "R5 sync then payload order", bad, 0);
    idx += k;
    k = run_len(idx);
    chk(ls_tr[idx] == tls && k == trail_e, "R8 trail level/length",
        int'(ls_tr[idx]) * 1000 + k, int'(tls) * 1000 + trail_e);
    idx += k;
    k = run_len(idx);
    chk(ls_tr[idx] == 3'd0 && k == exit_e + 1 && idx + k == tr_n && dn_tr[tr_n - 1],
        "R9 exit length before done", k - 1, exit_e);
    chk(taken == n, "R6 bytes accepted", taken, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit held;
    int taken;
    rst_n = 1'b0; start = 1'b0; clk_lane_ready = 1'b1; s_valid = 1'b0; s_data = '0;
    cfg_lpx = 8'd2; cfg_prepare = 8'd2; cfg_zero = 8'd2; cfg_trail = 8'd2; cfg_exit = 8'd2;
    cfg_hs_period = 8'd1; cfg_t60 = 8'd2;
    repeat (3) @(negedge clk);
    chk(line_state == 3'd0, "R1 reset line state", line_state, 0);
    chk(!s_ready, "R1 reset ready", s_ready, 0);
    chk(!tx_vld, "R1 reset tx_vld", tx_vld, 0);
    chk(!burst_done, "R1 reset done", burst_done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: request without clock lane readiness stays in stop state
    clk_lane_ready = 1'b0; start = 1'b1; s_valid = 1'b1; s_data = 8'h55;
    held = 1;
    repeat (20) begin
      @(negedge clk);
      if (line_state != 3'd0 || s_ready) held = 0;
    end
    chk(held, "R2 wait for clock lane", int'(held), 1);
    start = 1'b0; s_valid = 1'b0; clk_lane_ready = 1'b1;
    @(negedge clk);

    // vector table walk (R3..R9, R11 via zero fields)
    foreach (VECS[i]) begin
      check_burst(VECS[i], 1'b0);
      @(negedge clk);
      chk(!burst_done && line_state == 3'd0, "R9 done is one cycle", int'(burst_done), 0);
      repeat (2) @(negedge clk);
    end

    // R10: trail floor boundaries
    cfg_hs_period = 8'd3; cfg_t60 = 8'd14; cfg_trail = 8'd25; #1;
    chk(trail_short == 1'b1, "R10 trail 25 < 26", trail_short, 1);
    cfg_trail = 8'd26; #1;
    chk(trail_short == 1'b0, "R10 trail 26 == 26", trail_short, 0);
    cfg_hs_period = 8'd5; cfg_t60 = 8'd10; cfg_trail = 8'd39; #1;
    chk(trail_short == 1'b1, "R10 trail 39 < 40", trail_short, 1);
    cfg_trail = 8'd40; #1;
    chk(trail_short == 1'b0, "R10 trail 40 == 40", trail_short, 0);
    cfg_hs_period = 8'd1; cfg_t60 = 8'd2;
    @(negedge clk);

    // R12: done and a held request in the same cycle
    check_burst(56'h03020203040140, 1'b1);
    @(negedge clk);
    chk(line_state == 3'd1 && !burst_done, "R12 next LP-01 right after done", line_state, 1);
    start = 1'b0;
    held = 0;
    for (int c = 0; c < 500; c++) begin
      @(negedge clk);
      if (burst_done) begin
        held = 1;
        break;
      end
    end
    chk(held, "R7 empty second burst completes", int'(held), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end
endmodule